// File: doc/BRIEF.md
# Memory Clock Retune Sequencer

This block walks an external DRAM interface through a change of its clock frequency without losing memory contents. A single start request carries the target frequency in kHz. From there the sequencer drives a fixed order of steps. It puts the DRAM into self-refresh. It parks the memory clock on the crystal reference. It holds the delay-locked loop in reset and pulses a load strobe for the new divider and timing values. It moves the clock back to the PLL, releases the DLL and waits for lock. Last, it takes the DRAM out of self-refresh. Each step that depends on the outside world waits for a status handshake before moving on.

The block picks one of several timing sets from the requested frequency. It captures that set index when it accepts the request and holds it for the whole run. Each handshake wait has a timeout with a programmable limit. If a wait runs out, the sequencer stops in an error state. Self-refresh stays requested there, so the memory keeps its contents. A fresh start request clears the error and begins a new run.

Top module: `memclk_retune_seq`

## Requirements
- R1: After reset every output is 0. A start request seen in the idle state raises busy_o and bit 8 of dram_ctl_o (self-refresh request) on the next cycle. busy_o stays high through the done cycle and is low on the cycle after it.
- R2: The clock is not moved to the crystal until bit 1 of dram_stat_i (DRAM halted) is read as 1. Every other bit of dram_stat_i is ignored.
- R3: tset_o is the band index. It is 0 for a frequency at or below 24000 kHz, 1 for one at or below 48000 kHz, 2 for one at or below 96000 kHz, and 3 above that. The index is captured at acceptance and does not change while busy_o is high.
- R4: After the halt is seen, clk_xtal_sel_o rises. The sequencer stays parked, with the DLL reset bits low, while xtal_busy_i is 1.
- R5: Once xtal_busy_i reads 0, bits 24 (DLL reset) and 25 (DLL shift-reset) of dll_ctl_o rise together. clk_xtal_sel_o is still high, and this happens one cycle before the load strobe.
- R6: div_load_o is a one-cycle pulse while on the crystal. On the next cycle clk_xtal_sel_o falls with both DLL reset bits still high. The sequencer stays there while pll_busy_i is 1.
- R7: Once pll_busy_i reads 0, both DLL reset bits fall together. The sequencer then waits for bit 16 of dll_stat_i (DLL locked) and ignores the other bits of that word.
- R8: Self-refresh is dropped only after the lock is seen. done_o then pulses for one cycle, after bit 1 of dram_stat_i is read as 0.
- R9: A start request while busy_o is high has no effect on the step order or on tset_o.
- R10: When a wait step has counted tmo_limit_i cycles without its condition, the next edge enters the error state. There err_o is 1, busy_o is 0 and the self-refresh bit is 1.
- R11: A start request in the error state clears err_o and begins a new run, with busy_o high and self-refresh held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a frequency change |
| freq_khz_i | input | FREQ_W | Target frequency in kHz, sampled with start_i |
| tmo_limit_i | input | TMO_W | Cycle limit for each handshake wait |
| dram_stat_i | input | WORD_W | DRAM status word, bit 1 = halted |
| dll_stat_i | input | WORD_W | DLL status word, bit 16 = locked |
| xtal_busy_i | input | 1 | Clock switch to crystal still in progress |
| pll_busy_i | input | 1 | Clock switch back to PLL still in progress |
| dram_ctl_o | output | WORD_W | DRAM control word, bit 8 = self-refresh request |
| dll_ctl_o | output | WORD_W | DLL control word, bit 24 = reset, bit 25 = shift-reset |
| clk_xtal_sel_o | output | 1 | Run the memory clock from the crystal |
| div_load_o | output | 1 | One-cycle strobe to load the dividers and timings |
| tset_o | output | SET_W | Selected timing-set index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | A handshake wait timed out |

## Verification
All outputs are decoded from the state register. Each result therefore shows one clock edge after the input that causes it: busy and self-refresh one edge after start, each step change one edge after its handshake reads good, and done one edge after the halt status clears. A timeout shows tmo_limit_i+1 edges after the wait begins. The bench drives inputs and samples outputs on falling edges, one edge at a time. At each sample it checks both the step just reached and, while a handshake is held off, that the step has not moved.

// File: rtl/memclk_retune_pkg.sv
package memclk_retune_pkg;

    // Bit positions in the control and status words seen by neighbours
    localparam int unsigned SREF_BIT      = 8;
    localparam int unsigned HALT_BIT      = 1;
    localparam int unsigned DLL_RST_BIT   = 24;
    localparam int unsigned DLL_SHIFT_BIT = 25;
    localparam int unsigned DLL_LOCK_BIT  = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SREF_IN,
        ST_PARK,
        ST_DLL_HOLD,
        ST_LOAD,
        ST_UNPARK,
        ST_RELOCK,
        ST_SREF_OUT,
        ST_DONE,
        ST_ERR
    } seq_state_e;

endpackage

// File: rtl/mcs_band_sel.sv
module mcs_band_sel #(
    parameter int unsigned FREQ_W   = 20,
    parameter int unsigned N_SETS   = 4,
    parameter int unsigned BASE_KHZ = 24000,
    localparam int unsigned SET_W   = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic [SET_W-1:0]  idx_o
);
    logic [N_SETS-2:0] above;

    // Band edges double from the base upward
    for (genvar g = 0; g < N_SETS - 1; g++) begin : g_edge
        localparam longint unsigned EDGE = longint'(BASE_KHZ) << g;
        assign above[g] = (64'(freq_i) > EDGE);
    end

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N_SETS - 1; k++) begin
            idx_o = idx_o + SET_W'(above[k]);
        end
    end
endmodule

// File: rtl/mcs_wait_timer.sv
module mcs_wait_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)         cnt_d = '0;
        else if (!expired_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/memclk_retune_seq.sv
module memclk_retune_seq
    import memclk_retune_pkg::*;
#(
    parameter int unsigned FREQ_W   = 20,
    parameter int unsigned TMO_W    = 16,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned N_SETS   = 4,
    parameter int unsigned BASE_KHZ = 24000,
    localparam int unsigned SET_W   = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_khz_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic [WORD_W-1:0] dram_stat_i,
    input  logic [WORD_W-1:0] dll_stat_i,
    input  logic              xtal_busy_i,
    input  logic              pll_busy_i,
    output logic [WORD_W-1:0] dram_ctl_o,
    output logic [WORD_W-1:0] dll_ctl_o,
    output logic              clk_xtal_sel_o,
    output logic              div_load_o,
    output logic [SET_W-1:0]  tset_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [SET_W-1:0] tset;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic [SET_W-1:0] band_idx;
    logic             tmo_hit;
    logic             halted, locked;
    logic             sref_on, dll_hold;

    assign halted = dram_stat_i[HALT_BIT];
    assign locked = dll_stat_i[DLL_LOCK_BIT];

    mcs_band_sel #(
        .FREQ_W   (FREQ_W),
        .N_SETS   (N_SETS),
        .BASE_KHZ (BASE_KHZ)
    ) u_band (
        .freq_i (freq_khz_i),
        .idx_o  (band_idx)
    );

    mcs_wait_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (r_d.st != r_q.st),
        .limit_i   (tmo_limit_i),
        .expired_o (tmo_hit)
    );

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_ERR: begin
                if (start_i) begin
                    r_d.st   = ST_SREF_IN;
                    r_d.tset = band_idx;
                end
            end
            ST_SREF_IN: begin
                if (halted)       r_d.st = ST_PARK;
                else if (tmo_hit) r_d.st = ST_ERR;
            end
            ST_PARK: begin
                if (!xtal_busy_i) r_d.st = ST_DLL_HOLD;
                else if (tmo_hit) r_d.st = ST_ERR;
            end
            ST_DLL_HOLD: r_d.st = ST_LOAD;
            ST_LOAD:     r_d.st = ST_UNPARK;
            ST_UNPARK: begin
                if (!pll_busy_i)  r_d.st = ST_RELOCK;
                else if (tmo_hit) r_d.st = ST_ERR;
            end
            ST_RELOCK: begin
                if (locked)       r_d.st = ST_SREF_OUT;
                else if (tmo_hit) r_d.st = ST_ERR;
            end
            ST_SREF_OUT: begin
                if (!halted)      r_d.st = ST_DONE;
                else if (tmo_hit) r_d.st = ST_ERR;
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: ST_IDLE, tset: '0};
        else         r_q <= r_d;
    end

    // Moore output decode
    always_comb begin
        sref_on = r_q.st inside {ST_SREF_IN, ST_PARK, ST_DLL_HOLD, ST_LOAD,
                                 ST_UNPARK, ST_RELOCK, ST_ERR};
        dll_hold = r_q.st inside {ST_DLL_HOLD, ST_LOAD, ST_UNPARK};
        dram_ctl_o = '0;
        dram_ctl_o[SREF_BIT] = sref_on;
        dll_ctl_o = '0;
        dll_ctl_o[DLL_RST_BIT]   = dll_hold;
        dll_ctl_o[DLL_SHIFT_BIT] = dll_hold;
    end

    assign clk_xtal_sel_o = r_q.st inside {ST_PARK, ST_DLL_HOLD, ST_LOAD};
    assign div_load_o     = (r_q.st == ST_LOAD);
    assign busy_o         = !(r_q.st inside {ST_IDLE, ST_ERR});
    assign done_o         = (r_q.st == ST_DONE);
    assign err_o          = (r_q.st == ST_ERR);
    assign tset_o         = r_q.tset;
endmodule

// File: rtl/memclk_retune_chk.sv
module memclk_retune_chk #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned SET_W  = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [WORD_W-1:0] dram_stat_i,
    input logic [WORD_W-1:0] dll_stat_i,
    input logic [WORD_W-1:0] dram_ctl_o,
    input logic [WORD_W-1:0] dll_ctl_o,
    input logic              clk_xtal_sel_o,
    input logic              div_load_o,
    input logic [SET_W-1:0]  tset_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);
    AST_PARK_AFTER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_xtal_sel_o) |-> $past(dram_stat_i[1])); // R2
    AST_TSET_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(tset_o)); // R3
    AST_LOAD_ON_XTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_load_o |-> (clk_xtal_sel_o && dll_ctl_o[24] && dll_ctl_o[25])); // R5
    AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_load_o |=> !div_load_o); // R6
    AST_SREF_DROP_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dram_ctl_o[8]) |-> $past(dll_stat_i[16])); // R8
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8
    AST_ERR_KEEPS_SREF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (dram_ctl_o[8] && !busy_o)); // R10
endmodule

bind memclk_retune_seq memclk_retune_chk #(
    .WORD_W (WORD_W),
    .SET_W  (SET_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dram_stat_i    (dram_stat_i),
    .dll_stat_i     (dll_stat_i),
    .dram_ctl_o     (dram_ctl_o),
    .dll_ctl_o      (dll_ctl_o),
    .clk_xtal_sel_o (clk_xtal_sel_o),
    .div_load_o     (div_load_o),
    .tset_o         (tset_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/sim_memclk_retune_seq.sv
module sim_memclk_retune_seq;
    localparam int unsigned FREQ_W = 20;
    localparam int unsigned TMO_W  = 16;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned NVEC   = 8;
    localparam logic [WORD_W-1:0] DLL_BOTH = 32'h0300_0000;

    // stimulus frequency (kHz) and expected timing set (R3)
    localparam int unsigned VEC_F [NVEC] = '{24000, 1000, 24001, 48000,
                                             48001, 96000, 96001, 400000};
    localparam int unsigned VEC_S [NVEC] = '{0, 0, 1, 1, 2, 2, 3, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FREQ_W-1:0] freq = '0;
    logic [TMO_W-1:0]  tmo = 16'd100;
    logic [WORD_W-1:0] dram_stat = '0;
    logic [WORD_W-1:0] dll_stat = '0;
    logic xtal_busy = 1'b0;
    logic pll_busy = 1'b0;
    logic [WORD_W-1:0] dram_ctl, dll_ctl;
    logic xtal_sel, load, busy, done, err;
    logic [1:0] tset;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    memclk_retune_seq u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_khz_i(freq),
        .tmo_limit_i(tmo), .dram_stat_i(dram_stat), .dll_stat_i(dll_stat),
        .xtal_busy_i(xtal_busy), .pll_busy_i(pll_busy),
        .dram_ctl_o(dram_ctl), .dll_ctl_o(dll_ctl), .clk_xtal_sel_o(xtal_sel),
        .div_load_o(load), .tset_o(tset), .busy_o(busy), .done_o(done),
        .err_o(err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_seq(input int unsigned f, input int unsigned s);
        start = 1'b1; freq = FREQ_W'(f);
        step();                                     // accepted
        start = 1'b0;
        check("R1 busy up", busy, 1);
        check("R1 sref up", dram_ctl, 32'h100);
        check("R3 tset", tset, s);
        start = 1'b1; freq = FREQ_W'(400000);       // R9 ignored request
        dram_stat = ~32'h2;                          // R2 other bits set, halt clear
        step();
        start = 1'b0;
        check("R9 tset kept", tset, s);
        check("R2 no park yet", xtal_sel, 0);
        step();
        check("R2 still waiting", xtal_sel, 0);
        dram_stat = 32'h2; xtal_busy = 1'b1;
        step();                                     // park
        check("R4 xtal sel", xtal_sel, 1);
        check("R4 dll low", dll_ctl, 0);
        step();
        check("R4 held on busy", xtal_sel, 1);
        check("R4 dll still low", dll_ctl, 0);
        xtal_busy = 1'b0;
        step();                                     // dll hold
        check("R5 dll pair", dll_ctl, DLL_BOTH);
        check("R5 on xtal", xtal_sel, 1);
        check("R5 no load yet", load, 0);
        step();                                     // load
        check("R6 load", load, 1);
        check("R6 tset at load", tset, s);
        pll_busy = 1'b1;
        step();                                     // unpark
        check("R6 load pulse", load, 0);
        check("R6 back to pll", xtal_sel, 0);
        check("R6 dll held", dll_ctl, DLL_BOTH);
        step();
        check("R6 waits pll busy", dll_ctl, DLL_BOTH);
        pll_busy = 1'b0; dll_stat = ~32'h0001_0000;
        step();                                     // relock
        check("R7 dll released", dll_ctl, 0);
        check("R7 sref held", dram_ctl, 32'h100);
        step();
        check("R7 waits lock", dram_ctl, 32'h100);
        dll_stat = 32'h0001_0000;
        step();                                     // self-refresh exit
        check("R8 sref dropped", dram_ctl, 0);
        check("R8 no done yet", done, 0);
        step();
        check("R8 waits halt clear", done, 0);
        dram_stat = '0;
        step();
        check("R8 done", done, 1);
        check("R1 busy in done", busy, 1);
        step();
        check("R8 done pulse", done, 0);
        check("R1 busy down", busy, 0);
        dll_stat = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        step(); step();
        check("R1 reset sref", dram_ctl, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset dll", dll_ctl, 0);
        check("R1 reset err", err, 0);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < NVEC; i++) begin
            run_seq(VEC_F[i], VEC_S[i]);
            step();
        end

        // R10: timeout in the halt wait with limit 3
        tmo = 16'd3; dram_stat = '0;
        start = 1'b1; freq = FREQ_W'(50000);
        step();
        start = 1'b0;
        step(); step(); step();
        check("R10 no error before limit", err, 0);
        step();
        check("R10 error", err, 1);
        check("R10 sref kept", dram_ctl, 32'h100);
        check("R10 busy low", busy, 0);
        step();
        check("R10 error held", err, 1);

        // R11: new start clears error
        tmo = 16'd100;
        start = 1'b1; freq = FREQ_W'(10000);
        step();
        start = 1'b0;
        check("R11 error cleared", err, 0);
        check("R11 busy", busy, 1);
        check("R11 sref held", dram_ctl, 32'h100);
        check("R11 new tset", tset, 0);

        rst_n = 1'b0;
        step();
        check("R1 reset mid-run", busy, 0);
        rst_n = 1'b1;
        step();
        run_seq(30000, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule